// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed station manager for the two-wire PHY management bus. Software writes a mode word (frame format and clock divider), a PHY address with a register or device number, and 16 bits of write data. It then writes a command word that starts one serial frame. The block builds the whole frame, shifts it out on MDIO while it generates MDC, and sets a busy flag in the command register until the last bit has been sent.

In Clause 22 format one frame does a complete read or write. In Clause 45 format an indirect access takes two frames. An address frame first loads the 16-bit register address from the write-data register. A write or read frame then follows. The same 2-bit code in the command word means a different frame type in each format, so software must set the format bit before it issues codes. On a read the block releases its output enable from the turnaround onward and samples the PHY's data on rising MDC edges. When the frame ends it places the 16-bit result in the read-data register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the mode register reads format bit 0 and divider DIV_INIT (3). The command register reads 0, the read-data register reads 0, and MDC and the MDIO output enable are low.
- R2: A write to the command register (offset 0x50) with bit 8 set and a valid code starts a frame. Bit 16 of that register reads 1 from the next cycle until the last frame bit ends, and then reads 0.
- R3: With the mode register (offset 0x40) bit 8 at 0, each frame uses Clause 22 format, sent MSB first: 32 ones, start 01, opcode 10 for code 0 (read) or 01 for code 1 (write), the PHY field from address-register bits 12:8, the register field from address-register bits 4:0, turnaround 10 on a write, then 16 data bits. On a write those data bits come from bits 15:0 of the write-data register (offset 0x48).
- R4: With mode bit 8 at 1, each frame uses Clause 45 format with start 00. Code 0 sends opcode 00 with the write-data word as data (address frame). Code 1 sends opcode 01 with the write-data word (write). Code 2 sends opcode 11 (read). The device field comes from address-register bits 4:0.
- R5: On a read frame the output enable is low from the first turnaround bit to the end of the frame. The 16 data bits are sampled MSB first on rising MDC edges and appear in bits 15:0 of the read-data register (offset 0x4C) when busy clears. Address and write frames leave that register unchanged.
- R6: Mode bits 7:0 hold a divider D. While a frame runs, MDC stays high for D+1 clock cycles and low for D+1 clock cycles. MDIO changes only where MDC falls.
- R7: A command write that arrives while busy is 1 has no effect. The running frame continues unchanged and no further frame follows it.
- R8: A command write with bit 8 clear, with code 2 or 3 in Clause 22 format, or with code 3 in Clause 45 format starts nothing. Busy stays 0.
- R9: While no frame runs, MDC and the output enable are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Serial data driven toward the PHYs |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Serial data sampled from the shared line |

## Verification
Busy is due on the first clock after the command write. Each frame lasts 64 × 2(D+1) cycles. The read-data register changes on the same edge where busy clears. For these reasons the bench never assumes a finish time. It polls bit 16 and compares the captured frame and the read-data register only after it has seen busy at 0. The behavioural PHY records the line on each rising MDC edge, so the frame is fully captured before busy falls. MDC half periods are measured by sampling on falling clock edges. Checks that something is ignored count frames over a later idle window.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int ADDR_W = 8,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_INIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TA_BIT = CNT_W'(46);
  localparam logic [CNT_W-1:0] DATA_BIT = CNT_W'(48);
  localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] OFF_WDAT = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] OFF_RDAT = ADDR_W'('h4C);
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'('h50);

  logic             fmt45_q;
  logic [DIV_W-1:0] div_q, run_div, hcnt;
  logic [4:0]       phy_q, regno_q;
  logic [15:0]      wdat_q, rdat_q, rsh;
  logic [1:0]       code_q;
  logic             busy_q, rd_q, mdc_q;
  logic [CNT_W-1:0] bitcnt;
  logic [FRAME_BITS-1:0] shreg;

  wire wr_en     = reg_sel && reg_wr;
  wire cmd_wr    = wr_en && reg_addr == OFF_CMD;
  wire start_req = cmd_wr && reg_wdata[8];
  wire [1:0] code_in = reg_wdata[1:0];
  wire code_ok   = fmt45_q ? (code_in != 2'd3) : (code_in < 2'd2);
  wire start_ok  = start_req && code_ok && !busy_q;
  wire rd_in     = fmt45_q ? (code_in == 2'd2) : (code_in == 2'd0);
  wire half_done = hcnt == run_div;

  logic [1:0] op_in;
  always_comb begin
    if (fmt45_q)
      op_in = (code_in == 2'd0) ? 2'b00 : (code_in == 2'd1) ? 2'b01 : 2'b11;
    else
      op_in = (code_in == 2'd0) ? 2'b10 : 2'b01;
  end

  wire [FRAME_BITS-1:0] frame_in = {32'hFFFF_FFFF, fmt45_q ? 2'b00 : 2'b01, op_in,
                                    phy_q, regno_q, 2'b10, rd_in ? 16'hFFFF : wdat_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt45_q <= 1'b0;
      div_q   <= DIV_INIT;
      phy_q   <= '0;
      regno_q <= '0;
      wdat_q  <= '0;
    end else if (wr_en) begin
      case (reg_addr)
        OFF_MODE: begin
          fmt45_q <= reg_wdata[8];
          div_q   <= reg_wdata[DIV_W-1:0];
        end
        OFF_ADDR: begin
          phy_q   <= reg_wdata[12:8];
          regno_q <= reg_wdata[4:0];
        end
        OFF_WDAT: wdat_q <= reg_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      code_q  <= '0;
      mdc_q   <= 1'b0;
      hcnt    <= '0;
      run_div <= '0;
      bitcnt  <= '0;
      shreg   <= '1;
      rsh     <= '0;
      rdat_q  <= '0;
    end else if (start_ok) begin
      busy_q  <= 1'b1;
      rd_q    <= rd_in;
      code_q  <= code_in;
      mdc_q   <= 1'b0;
      hcnt    <= '0;
      run_div <= div_q;
      bitcnt  <= '0;
      shreg   <= frame_in;
    end else if (busy_q) begin
      if (!half_done) begin
        hcnt <= hcnt + 1'b1;
      end else begin
        hcnt  <= '0;
        mdc_q <= !mdc_q;
        if (!mdc_q) begin
          if (rd_q && bitcnt >= DATA_BIT) rsh <= {rsh[14:0], mdio_i};
        end else if (bitcnt == LAST_BIT) begin
          busy_q <= 1'b0;
          if (rd_q) rdat_q <= rsh;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          shreg  <= {shreg[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  assign mdc_o   = mdc_q;
  assign mdio_o  = shreg[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && bitcnt >= TA_BIT);

  always_comb begin
    case (reg_addr)
      OFF_MODE: reg_rdata = {23'd0, fmt45_q, {(8-DIV_W){1'b0}}, div_q};
      OFF_ADDR: reg_rdata = {19'd0, phy_q, 3'd0, regno_q};
      OFF_WDAT: reg_rdata = {16'd0, wdat_q};
      OFF_RDAT: reg_rdata = {16'd0, rdat_q};
      OFF_CMD:  reg_rdata = {15'd0, busy_q, 14'd0, code_q};
      default:  reg_rdata = '0;
    endcase
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc_o && !mdio_oe));
  a_r6_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$fell(mdc_o)) |-> $stable(mdio_o));
  a_r2_busy_ends_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(bitcnt) == LAST_BIT && $fell(mdc_o)));
  a_r7_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_req) |=> ($stable(rd_q) && $stable(code_q)));
  a_r8_bad_code_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cmd_wr && !(reg_wdata[8] && code_ok)) |=> !busy_q);
endmodule

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc_o, mdio_o, mdio_oe, mdio_line;
  logic phy_en = 1'b0, phy_bit = 1'b1;
  int checks = 0, errors = 0, conflicts = 0, frame_cnt = 0, idx = 0;
  logic [63:0] fr = '0, last_frame = '0;
  logic phy_rd = 1'b0;
  logic [15:0] phy_val = '0;

  always #2.5 clk = !clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line));

  function automatic logic [15:0] phy_resp(logic [4:0] p, logic [4:0] r);
    return {p, r, 6'h2D} ^ 16'h5A3C;
  endfunction

  function automatic logic [63:0] exp_frame(logic f45, logic [1:0] code, logic [4:0] p,
                                            logic [4:0] r, logic [15:0] wd);
    logic [1:0] op;
    logic rd;
    rd = f45 ? (code == 2'd2) : (code == 2'd0);
    if (f45) op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
    else     op = (code == 2'd0) ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, f45 ? 2'b00 : 2'b01, op, p, r, 2'b10, rd ? phy_resp(p, r) : wd};
  endfunction

  always @(posedge mdc_o) begin
    fr = {fr[62:0], mdio_line};
    idx = idx + 1;
    if (idx == 36) phy_rd = (fr[3:0] == 4'b0110) || (fr[3:0] == 4'b0011);
    if (idx == 46) phy_val = phy_resp(fr[9:5], fr[4:0]);
    if (phy_rd && idx == 47) begin phy_en = 1'b1; phy_bit = 1'b0; end
    else if (phy_rd && idx >= 48 && idx < 64) phy_bit = phy_val[63 - idx];
    if (idx == 64) begin
      phy_en = 1'b0; phy_bit = 1'b1; phy_rd = 1'b0;
      last_frame = fr; frame_cnt++; idx = 0;
    end
  end

  always @(negedge clk) if (mdio_oe && phy_en) conflicts++;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_wr = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_sel = 1; reg_wr = 0;
    #1 d = reg_rdata; reg_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(8'h50, v);
      if (!v[16]) return;
    end
    chk("R2 busy never cleared", 1, 0);
  endtask

  task automatic run_frame(logic f45, logic [1:0] code, logic [4:0] p, logic [4:0] r,
                           logic [15:0] wd, logic [7:0] dv);
    bus_wr(8'h40, {23'd0, f45, dv});
    bus_wr(8'h44, {19'd0, p, 3'd0, r});
    bus_wr(8'h48, {16'd0, wd});
    bus_wr(8'h50, {23'd0, 1'b1, 6'd0, code});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] exp_rd;
    int fc, hi, lo;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(8'h40, v); chk("R1 mode", v, 32'h3);
    bus_rd(8'h50, v); chk("R1 cmd", v, 0);
    bus_rd(8'h4C, v); chk("R1 rdata", v, 0);
    chk("R1 R9 pins", {mdc_o, mdio_oe}, 0);
    exp_rd = 0;

    // R3 Clause 22 write, R2 busy
    run_frame(0, 1, 5'h11, 5'h03, 16'hBEEF, 8'd0);
    bus_rd(8'h50, v); chk("R2 busy set", v[16], 1);
    wait_idle();
    chk("R3 c22 write frame", last_frame, exp_frame(0, 1, 5'h11, 5'h03, 16'hBEEF));
    bus_rd(8'h4C, v); chk("R5 rdata kept after write", v[15:0], exp_rd);
    chk("R9 idle pins", {mdc_o, mdio_oe}, 0);

    // R3 R5 Clause 22 read
    run_frame(0, 0, 5'h1F, 5'h1E, 16'h0, 8'd1);
    wait_idle();
    exp_rd = phy_resp(5'h1F, 5'h1E);
    chk("R3 c22 read frame", last_frame, exp_frame(0, 0, 5'h1F, 5'h1E, 0));
    bus_rd(8'h4C, v); chk("R5 c22 rdata", v[15:0], exp_rd);

    // R4 Clause 45 address, write, read
    run_frame(1, 0, 5'h02, 5'h07, 16'h8001, 8'd0); wait_idle();
    chk("R4 c45 addr frame", last_frame, exp_frame(1, 0, 5'h02, 5'h07, 16'h8001));
    run_frame(1, 1, 5'h02, 5'h07, 16'h1234, 8'd0); wait_idle();
    chk("R4 c45 write frame", last_frame, exp_frame(1, 1, 5'h02, 5'h07, 16'h1234));
    run_frame(1, 2, 5'h02, 5'h07, 16'h0, 8'd0); wait_idle();
    exp_rd = phy_resp(5'h02, 5'h07);
    chk("R4 c45 read frame", last_frame, exp_frame(1, 2, 5'h02, 5'h07, 0));
    bus_rd(8'h4C, v); chk("R5 c45 rdata", v[15:0], exp_rd);

    // R6 divider timing
    run_frame(0, 1, 5'h05, 5'h09, 16'hA55A, 8'd2);
    @(negedge clk); while (!mdc_o) @(negedge clk);
    hi = 0; while (mdc_o) begin hi++; @(negedge clk); end
    lo = 0; while (!mdc_o) begin lo++; @(negedge clk); end
    chk("R6 mdc high cycles", hi, 3);
    chk("R6 mdc low cycles", lo, 3);
    wait_idle();
    chk("R6 frame intact", last_frame, exp_frame(0, 1, 5'h05, 5'h09, 16'hA55A));

    // R7 command while busy
    fc = frame_cnt;
    run_frame(0, 1, 5'h0A, 5'h0B, 16'h0F0F, 8'd0);
    repeat (20) @(negedge clk);
    bus_wr(8'h50, 32'h100);
    wait_idle();
    repeat (400) @(negedge clk);
    chk("R7 single frame", frame_cnt - fc, 1);
    chk("R7 frame unchanged", last_frame, exp_frame(0, 1, 5'h0A, 5'h0B, 16'h0F0F));
    bus_rd(8'h4C, v); chk("R7 rdata unchanged", v[15:0], exp_rd);

    // R8 invalid codes / no start bit
    fc = frame_cnt;
    bus_wr(8'h40, 32'h0);
    bus_wr(8'h50, 32'h102); bus_rd(8'h50, v); chk("R8 c22 code2 busy", v[16], 0);
    bus_wr(8'h50, 32'h001); bus_rd(8'h50, v); chk("R8 no start busy", v[16], 0);
    bus_wr(8'h40, 32'h100);
    bus_wr(8'h50, 32'h103); bus_rd(8'h50, v); chk("R8 c45 code3 busy", v[16], 0);
    repeat (300) @(negedge clk);
    chk("R8 no frames", frame_cnt - fc, 0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic f45;
      logic [1:0] code;
      logic [4:0] p, r;
      logic [15:0] wd;
      logic [7:0] dv;
      f45 = 1'($urandom % 2);
      code = f45 ? 2'($urandom % 3) : 2'($urandom % 2);
      p = 5'($urandom); r = 5'($urandom); wd = 16'($urandom); dv = 8'($urandom % 3);
      run_frame(f45, code, p, r, wd, dv);
      wait_idle();
      chk(f45 ? "R4 random frame" : "R3 random frame", last_frame, exp_frame(f45, code, p, r, wd));
      if (f45 ? (code == 2) : (code == 0)) exp_rd = phy_resp(p, r);
      bus_rd(8'h4C, v); chk("R5 random rdata", v[15:0], exp_rd);
    end

    chk("R5 no line conflict", conflicts, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule